// File: doc/BRIEF.md
# FIFO Write-Through Set-Associative Cache Bank

This block is one bank of a set-associative cache that sits between a requester and a slower next level of memory. The number of set-index bits, the number of ways per set and the number of block-offset bits are all parameters. Setting the set-index bits to zero gives a fully associative bank. Each line holds a tag, a valid flag, a fill stamp and one block of data. The bank reports a hit or a miss for every access. It keeps three running totals: hits, misses and evictions.

A read that hits returns the whole block one cycle after it is accepted. A read that misses issues a single block-aligned fetch downstream and stalls until the block arrives. The block is then installed and returned. Victims are chosen in insertion order: a free way is taken first, otherwise the line that was filled earliest is replaced. Hits leave that order unchanged. Writes are write-through with no allocation. Every write is forwarded downstream with a byte-enable mask. A write that hits also merges its enabled bytes into the cached line. A write that misses leaves the bank's contents unchanged.

Top module: `fifo_wt_cache`

## Requirements
- R1: Address fields: bits [OFF_BITS-1:0] are the byte offset inside a block, the next SET_BITS bits select the set, and the remaining upper bits are the tag. Two blocks with equal tags but different sets occupy separate lines.
- R2: For two cycles after the asynchronous reset is released, `req_ready` stays low. Afterwards all lines are invalid, `req_ready` is 1, all counters are 0, and no response or downstream request is active.
- R3: A read that hits drives `resp_valid`=1 and `resp_hit`=1 in the cycle after acceptance. `resp_rdata` carries the cached block, `hit_count` increases by one, and no downstream read is issued.
- R4: A read that misses raises `mem_rd_req` in the cycle after acceptance, with `mem_addr` equal to the block address (offset bits zero). `mem_rd_req` stays high and `req_ready` stays low until `mem_rd_valid`. At that edge the block is installed and `resp_valid`=1 with `resp_hit`=0 and `resp_rdata`=`mem_rd_data`. `miss_count` increases by one at acceptance.
- R5: On a fill, the lowest-numbered invalid way of the set is used if one exists. Such a fill does not change `evict_count`.
- R6: When the set is full, the line filled earliest is replaced and `evict_count` increases by one. Hits do not change the replacement order.
- R7: A write that hits changes exactly the bytes at offsets `off` to `off+size-1` of the cached line; all other bytes keep their values. It counts as a hit and returns `resp_hit`=1.
- R8: Every accepted write raises `mem_wr_req` and `resp_valid` in the next cycle, with `mem_addr` set to the request address. A write that misses counts as a miss, allocates no line and gives `resp_hit`=0, so a later read of that block misses.
- R9: Byte lane k of `req_wdata`, `mem_wdata`, `resp_rdata` and `mem_rd_data` is bits [8k+7:8k], holding the byte at block offset k. Bit k of `mem_be` is 1 exactly when k lies between `off` and `off+size-1`, where `req_size` ranges from 1 to the block size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | OFF_BITS+1 | Bytes accessed, 1 to block size |
| req_wdata | input | 8*2^OFF_BITS | Write data placed in block byte lanes |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Access hit in the bank |
| resp_rdata | output | 8*2^OFF_BITS | Block returned for reads |
| mem_rd_req | output | 1 | Block fetch request, held until data returns |
| mem_wr_req | output | 1 | Write-through strobe |
| mem_addr | output | ADDR_W | Downstream address |
| mem_be | output | 2^OFF_BITS | Downstream byte enables for writes |
| mem_wdata | output | 8*2^OFF_BITS | Downstream write data |
| mem_rd_valid | input | 1 | Fetched block is on mem_rd_data |
| mem_rd_data | input | 8*2^OFF_BITS | Fetched block |
| hit_count | output | CNT_W | Total hits |
| miss_count | output | CNT_W | Total misses |
| evict_count | output | CNT_W | Total replacements of valid lines |

## Verification
The bench goes after the replacement order in a full set. It places a hit on the oldest line just before a conflicting miss. A design that refreshed order on hits, as LRU does, would evict the wrong block, and a later access would report the wrong hit flag. Writes are aimed at partial byte ranges at every offset and size. A wrong enable mask would corrupt neighbouring bytes, and the corruption shows on the next read hit or on `mem_be`. Write misses are followed by reads of the same block. A bank that allocated on a write miss would report a hit there, and one that dropped the write would return stale memory bytes. A long swept stream over two sets and sixteen blocks is checked against a reference model kept in the bench. It also exercises the fill-a-free-way-first rule, where a wrong rule would shift `evict_count`.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} fill_state_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cache_byte_mask.sv
module cache_byte_mask #(
  parameter int OFF_BITS = 3
) (
  input  logic [OFF_BITS-1:0]      off,
  input  logic [OFF_BITS:0]        size,
  output logic [(1<<OFF_BITS)-1:0] be
);
  localparam int BYTES = 1 << OFF_BITS;

  logic [OFF_BITS+1:0] first_b;
  logic [OFF_BITS+1:0] last_ex;

  assign first_b = {2'b00, off};
  assign last_ex = {2'b00, off} + {1'b0, size};

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign be[k] = ((OFF_BITS+2)'(k) >= first_b) && ((OFF_BITS+2)'(k) < last_ex);
  end
endmodule

// File: rtl/cache_way_select.sv
module cache_way_select
  import cache_pkg::*;
#(
  parameter int WAYS    = 2,
  parameter int TAG_W   = 6,
  parameter int STAMP_W = 16,
  parameter int WAY_W   = idx_width(WAYS)
) (
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
  input  logic [WAYS-1:0][STAMP_W-1:0] way_stamp,
  input  logic [TAG_W-1:0]             look_tag,
  output logic                         hit,
  output logic [WAY_W-1:0]             hit_way,
  output logic [WAY_W-1:0]             victim_way,
  output logic                         victim_valid
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == look_tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] oldest_way;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) free_way = WAY_W'(w);
    end
    oldest_way = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (way_stamp[w] < way_stamp[oldest_way]) oldest_way = WAY_W'(w);
    end
  end

  assign victim_valid = &way_valid;
  assign victim_way   = victim_valid ? oldest_way : free_way;
endmodule

// File: rtl/fifo_wt_cache.sv
module fifo_wt_cache
  import cache_pkg::*;
#(
  parameter int SET_BITS = 1,
  parameter int WAYS     = 2,
  parameter int OFF_BITS = 3,
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 16,
  parameter int STAMP_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [OFF_BITS:0]          req_size,
  input  logic [8*(1<<OFF_BITS)-1:0] req_wdata,
  output logic                       resp_valid,
  output logic                       resp_hit,
  output logic [8*(1<<OFF_BITS)-1:0] resp_rdata,
  output logic                       mem_rd_req,
  output logic                       mem_wr_req,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [(1<<OFF_BITS)-1:0]   mem_be,
  output logic [8*(1<<OFF_BITS)-1:0] mem_wdata,
  input  logic                       mem_rd_valid,
  input  logic [8*(1<<OFF_BITS)-1:0] mem_rd_data,
  output logic [CNT_W-1:0]           hit_count,
  output logic [CNT_W-1:0]           miss_count,
  output logic [CNT_W-1:0]           evict_count
);
  localparam int BYTES  = 1 << OFF_BITS;
  localparam int BLK_W  = 8 * BYTES;
  localparam int SETS   = 1 << SET_BITS;
  localparam int SET_IW = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int TAG_W  = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_W  = idx_width(WAYS);

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // line storage
  logic [WAYS-1:0]              valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
  logic [WAYS-1:0][STAMP_W-1:0] stamp_q [SETS];
  logic [BLK_W-1:0]             data_q  [SETS][WAYS];

  fill_state_t         state_q, state_d;
  logic [SET_IW-1:0]   hold_set_q;
  logic [TAG_W-1:0]    hold_tag_q;
  logic [STAMP_W-1:0]  stamp_ctr_q;

  // address split
  logic [TAG_W-1:0]    req_tag;
  logic [SET_IW-1:0]   req_set;
  logic [SET_IW-1:0]   look_set;
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  if (SET_BITS > 0) begin : g_set
    assign req_set = req_addr[OFF_BITS +: SET_BITS];
  end else begin : g_noset
    assign req_set = '0;
  end
  assign look_set = (state_q == ST_FETCH) ? hold_set_q : req_set;

  logic             look_hit, victim_valid;
  logic [WAY_W-1:0] hit_way, victim_way;

  cache_way_select #(.WAYS(WAYS), .TAG_W(TAG_W), .STAMP_W(STAMP_W), .WAY_W(WAY_W)) u_sel (
    .way_valid   (valid_q[look_set]),
    .way_tag     (tag_q[look_set]),
    .way_stamp   (stamp_q[look_set]),
    .look_tag    (req_tag),
    .hit         (look_hit),
    .hit_way     (hit_way),
    .victim_way  (victim_way),
    .victim_valid(victim_valid)
  );

  logic [BYTES-1:0] req_be;
  cache_byte_mask #(.OFF_BITS(OFF_BITS)) u_mask (
    .off (req_addr[OFF_BITS-1:0]),
    .size(req_size),
    .be  (req_be)
  );

  logic             accept, fill, wr_hit;
  logic [BLK_W-1:0] hit_line, merged;
  assign req_ready = core_rst_n && (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign fill      = (state_q == ST_FETCH) && mem_rd_valid;
  assign wr_hit    = accept && req_write && look_hit;
  assign hit_line  = data_q[look_set][hit_way];

  always_comb begin
    for (int k = 0; k < BYTES; k++) begin
      merged[8*k +: 8] = req_be[k] ? req_wdata[8*k +: 8] : hit_line[8*k +: 8];
    end
  end

  // next-state and output logic
  logic               resp_valid_d, resp_hit_d, rd_req_d, wr_req_d;
  logic [BLK_W-1:0]   rdata_d, wdata_d;
  logic [ADDR_W-1:0]  addr_d;
  logic [BYTES-1:0]   be_d;

  always_comb begin
    state_d      = state_q;
    resp_valid_d = 1'b0;
    resp_hit_d   = resp_hit;
    rdata_d      = resp_rdata;
    rd_req_d     = mem_rd_req;
    wr_req_d     = 1'b0;
    addr_d       = mem_addr;
    be_d         = mem_be;
    wdata_d      = mem_wdata;
    if (accept) begin
      if (req_write) begin
        wr_req_d     = 1'b1;
        addr_d       = req_addr;
        be_d         = req_be;
        wdata_d      = req_wdata;
        resp_valid_d = 1'b1;
        resp_hit_d   = look_hit;
        rdata_d      = look_hit ? merged : req_wdata;
      end else if (look_hit) begin
        resp_valid_d = 1'b1;
        resp_hit_d   = 1'b1;
        rdata_d      = hit_line;
      end else begin
        state_d  = ST_FETCH;
        rd_req_d = 1'b1;
        addr_d   = {req_addr[ADDR_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
      end
    end else if (fill) begin
      state_d      = ST_IDLE;
      rd_req_d     = 1'b0;
      resp_valid_d = 1'b1;
      resp_hit_d   = 1'b0;
      rdata_d      = mem_rd_data;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q     <= ST_IDLE;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_rdata  <= '0;
      mem_rd_req  <= 1'b0;
      mem_wr_req  <= 1'b0;
      mem_addr    <= '0;
      mem_be      <= '0;
      mem_wdata   <= '0;
      hit_count   <= '0;
      miss_count  <= '0;
      evict_count <= '0;
      stamp_ctr_q <= '0;
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      state_q    <= state_d;
      resp_valid <= resp_valid_d;
      resp_hit   <= resp_hit_d;
      resp_rdata <= rdata_d;
      mem_rd_req <= rd_req_d;
      mem_wr_req <= wr_req_d;
      mem_addr   <= addr_d;
      mem_be     <= be_d;
      mem_wdata  <= wdata_d;
      if (accept && look_hit)           hit_count   <= hit_count + 1'b1;
      if (accept && !look_hit)          miss_count  <= miss_count + 1'b1;
      if (fill && victim_valid)         evict_count <= evict_count + 1'b1;
      if (fill)                         stamp_ctr_q <= stamp_ctr_q + 1'b1;
      if (fill) valid_q[hold_set_q][victim_way] <= 1'b1;
    end
  end

  // storage without reset, written under explicit enables
  always_ff @(posedge clk) begin
    if (accept) begin
      hold_set_q <= req_set;
      hold_tag_q <= req_tag;
    end
    if (fill) begin
      tag_q[hold_set_q][victim_way]   <= hold_tag_q;
      stamp_q[hold_set_q][victim_way] <= stamp_ctr_q;
      data_q[hold_set_q][victim_way]  <= mem_rd_data;
    end
    if (wr_hit) data_q[req_set][hit_way] <= merged;
  end
endmodule

// File: rtl/cache_checks.sv
module cache_checks #(
  parameter int OFF_BITS = 3,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                look_hit,
  input logic                resp_valid,
  input logic                resp_hit,
  input logic                mem_rd_req,
  input logic                mem_wr_req,
  input logic                mem_rd_valid,
  input logic [OFF_BITS-1:0] mem_addr_lo,
  input logic [CNT_W-1:0]    hit_count,
  input logic [CNT_W-1:0]    evict_count
);
  a_r3_read_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && look_hit |=> resp_valid && resp_hit && !mem_rd_req);

  a_r3_hit_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && look_hit |=> hit_count == $past(hit_count) + 1'b1);

  a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req);

  a_r4_stall_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);

  a_r4_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> mem_addr_lo == '0);

  a_r6_evict_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evict_count) |-> $past(mem_rd_req && mem_rd_valid));

  a_r8_write_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> mem_wr_req && resp_valid);

  a_r8_no_dual_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));
endmodule

bind fifo_wt_cache cache_checks #(.OFF_BITS(OFF_BITS), .CNT_W(CNT_W)) u_checks (
  .clk         (clk),
  .rst_n       (core_rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .look_hit    (look_hit),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .mem_rd_req  (mem_rd_req),
  .mem_wr_req  (mem_wr_req),
  .mem_rd_valid(mem_rd_valid),
  .mem_addr_lo (mem_addr[OFF_BITS-1:0]),
  .hit_count   (hit_count),
  .evict_count (evict_count)
);

// File: tb/tb_fifo_wt_cache.sv
module tb_fifo_wt_cache;
  localparam int SET_BITS = 1, WAYS = 2, OFF_BITS = 3, ADDR_W = 10, CNT_W = 16;
  localparam int NBLK = 1 << (ADDR_W - OFF_BITS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, resp_valid, resp_hit;
  logic mem_rd_req, mem_wr_req, mem_rd_valid;
  logic [ADDR_W-1:0] req_addr, mem_addr;
  logic [3:0] req_size;
  logic [63:0] req_wdata, resp_rdata, mem_wdata, mem_rd_data;
  logic [7:0] mem_be;
  logic [CNT_W-1:0] hit_count, miss_count, evict_count;

  fifo_wt_cache #(.SET_BITS(SET_BITS), .WAYS(WAYS), .OFF_BITS(OFF_BITS),
                  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STAMP_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_rdata(resp_rdata), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // bench memory and reference cache model
  logic [63:0] mem [NBLK];
  bit          m_valid [2][2];
  int          m_tag   [2][2];
  int          m_stamp [2][2];
  logic [63:0] m_data  [2][2];
  int m_time = 0, e_hit = 0, e_miss = 0, e_evict = 0;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input string lbl, input bit wr, input logic [9:0] a,
                        input int sz, input logic [63:0] wd);
    int set, tag, blk, off, way;
    bit hit;
    logic [7:0] be;
    logic [63:0] merged;
    set = int'(a[3]); tag = int'(a[9:4]); blk = int'(a[9:3]); off = int'(a[2:0]);
    hit = 0; way = 0;
    for (int w = 0; w < 2; w++)
      if (m_valid[set][w] && m_tag[set][w] == tag) begin hit = 1; way = w; end
    for (int k = 0; k < 8; k++) be[k] = (k >= off) && (k < off + sz);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = 4'(sz); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (hit) e_hit++; else e_miss++;
    if (wr) begin
      check(mem_wr_req && mem_addr == a, {lbl, " R8 write forwarded"}, 64'(mem_addr), 64'(a));
      check(mem_be == be, {lbl, " R9 byte enables"}, 64'(mem_be), 64'(be));
      check(mem_wdata == wd, {lbl, " R9 write data lanes"}, mem_wdata, wd);
      check(resp_valid && resp_hit == hit, {lbl, " R7 R8 write hit flag"}, 64'(resp_hit), 64'(hit));
      merged = mem[blk];
      for (int k = 0; k < 8; k++) if (be[k]) merged[8*k +: 8] = wd[8*k +: 8];
      mem[blk] = merged;
      if (hit) begin
        for (int k = 0; k < 8; k++) if (be[k]) m_data[set][way][8*k +: 8] = wd[8*k +: 8];
      end
    end else if (hit) begin
      check(resp_valid && resp_hit && !mem_rd_req, {lbl, " R3 read hit response"}, 64'(resp_hit), 64'd1);
      check(resp_rdata == m_data[set][way], {lbl, " R3 R7 hit data"}, resp_rdata, m_data[set][way]);
    end else begin
      check(mem_rd_req && !resp_valid && !req_ready, {lbl, " R4 fetch issued"}, 64'(mem_rd_req), 64'd1);
      check(mem_addr == {a[9:3], 3'b000}, {lbl, " R1 R4 fetch address"}, 64'(mem_addr), 64'({a[9:3], 3'b000}));
      @(negedge clk);
      check(mem_rd_req, {lbl, " R4 fetch held"}, 64'(mem_rd_req), 64'd1);
      mem_rd_valid = 1; mem_rd_data = mem[blk];
      @(negedge clk);
      mem_rd_valid = 0; mem_rd_data = '0;
      check(resp_valid && !resp_hit && !mem_rd_req, {lbl, " R4 miss response"}, 64'(resp_hit), 64'd0);
      check(resp_rdata == mem[blk], {lbl, " R4 fetched data"}, resp_rdata, mem[blk]);
      way = -1;
      for (int w = 1; w >= 0; w--) if (!m_valid[set][w]) way = w;
      if (way < 0) begin
        way = (m_stamp[set][1] < m_stamp[set][0]) ? 1 : 0;
        e_evict++;
      end
      m_valid[set][way] = 1; m_tag[set][way] = tag;
      m_stamp[set][way] = m_time++; m_data[set][way] = mem[blk];
    end
    check(hit_count == CNT_W'(e_hit) && miss_count == CNT_W'(e_miss),
          {lbl, " R3 R4 hit/miss totals"}, {hit_count, miss_count}, {16'(e_hit), 16'(e_miss)});
    check(evict_count == CNT_W'(e_evict), {lbl, " R5 R6 eviction total"}, 64'(evict_count), 64'(e_evict));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NBLK; i++) mem[i] = {32'hC0DE0000 | 32'(i), 32'h5A5A5A5A ^ (32'(i) * 32'h01010101)};
    for (int s = 0; s < 2; s++) for (int w = 0; w < 2; w++) m_valid[s][w] = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_size = 4'd1;
    req_wdata = '0; mem_rd_valid = 0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!req_ready, "R2 ready low during reset release", 64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    check(req_ready && !resp_valid && !mem_rd_req && !mem_wr_req, "R2 idle after reset",
          64'({req_ready, resp_valid, mem_rd_req, mem_wr_req}), 64'b1000);
    check(hit_count == 0 && miss_count == 0 && evict_count == 0, "R2 counters zero",
          64'(hit_count + miss_count + evict_count), 64'd0);

    // directed: fill order, FIFO order with hits, set separation
    access("d1", 0, 10'h000, 4, '0);
    access("d2", 0, 10'h004, 2, '0);           // R3 same block hit
    access("d3", 0, 10'h010, 8, '0);           // R5 second way of set 0
    access("d4", 0, 10'h018, 1, '0);           // R1 same tag, set 1
    check(evict_count == 0, "R5 free ways filled without eviction", 64'(evict_count), 64'd0);
    access("d5", 0, 10'h000, 8, '0);           // hit on oldest line
    access("d6", 0, 10'h020, 8, '0);           // R6 evicts 0x000 despite hit
    check(evict_count == 1, "R6 first eviction", 64'(evict_count), 64'd1);
    access("d7", 0, 10'h010, 8, '0);           // R6 0x010 survived
    access("d8", 0, 10'h000, 8, '0);           // R6 miss, evicts 0x010
    // write hit with partial range, then read back
    access("d9", 1, 10'h022, 3, 64'h0000_00AB_CDEF_0000);
    access("d10", 0, 10'h020, 8, '0);          // R7 merged bytes visible
    // write miss: no allocation
    access("d11", 1, 10'h047, 1, 64'h7700_0000_0000_0000);
    access("d12", 0, 10'h040, 8, '0);          // R8 must miss, sees written byte

    // sweep: two sets, sixteen blocks, all offsets and sizes
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] a;
      int off, sz;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {3'b000, lfsr[6:0]};
      off = int'(a[2:0]);
      sz = 1 + (int'(lfsr[11:8]) % (8 - off));
      access("sweep", lfsr[14:13] == 2'b00, a, sz, {lfsr, ~lfsr, lfsr ^ 16'h3C3C, lfsr + 16'h1111});
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule